// File: doc/BRIEF.md
# Dead-Time Generator with Break

This block drives a half-bridge gate pair from one reference PWM. The high-side drive follows the reference and the low-side drive follows its complement. After a switch turns off, the opposite switch waits a programmable number of clock cycles before it turns on. The dead-time count is an 8-bit value by default. Software can write it until a write-once lock bit is set. After that the value holds until reset.

A main output enable (MOE) register decides which targets the drives follow. While MOE is set, the drives follow the reference. While it is clear, each drive goes to a configured safe state: a fixed idle level, or released (drive low with its enable deasserted, meaning high impedance). A break input with selectable polarity clears MOE. Only a software set request while the break is inactive can set MOE again. The dead-time rule also applies when entering the safe state and when leaving it. A switch that the safe state turns on is switched on only after the opposite side has been off for the full dead time.

Top module: `deadtime_brk`

## Requirements
- R1: With a nonzero dead time D, a reference change sampled at clock edge k switches the conducting side off at edge k. Both drives then stay low through edge k+D-1, and the new side turns on at edge k+D.
- R2: `hs_drv` and `ls_drv` are never high in the same cycle.
- R3: With D = 0, a reference change sampled at edge k swaps the two drives at that same edge, with no gap cycle.
- R4: If the reference returns to its previous level before the dead time has run out, the side that the pulse would have turned on stays low for the whole pulse.
- R5: A write to `dt_val` (with `dt_wr`) takes effect at the next edge. Once `dt_lock` has been seen at an edge, later dead-time writes are ignored until reset. A write in the same cycle as the lock still lands.
- R6: Reset clears MOE, both drives and both enables. While MOE is clear, the drives follow the safe state and do not follow the reference.
- R7: The break is active when `brk_in` equals `brk_pol`. An active break sampled at edge e clears MOE at edge e. The drives begin moving to the safe state at edge e+1.
- R8: `moe_set` sampled at an edge where the break is inactive sets MOE at that edge. The drives begin following the reference one edge later. A set request while the break is active is ignored.
- R9: In the safe state, `hiz_hi`/`hiz_lo` release a side: its drive is low and its enable is deasserted. Otherwise `idle_hi`/`idle_lo` give the side's level. If both idle levels are high, only the low side turns on. Each enable is `1` when MOE is set, and updates one edge after MOE.
- R10: When a safe-state entry or an MOE restart turns on a side whose opposite side is conducting, the opposite side goes off first. The turn-on then waits the dead time, exactly as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_pwm | input | 1 | Reference PWM |
| brk_in | input | 1 | Break request |
| brk_pol | input | 1 | Level of `brk_in` that means break |
| dt_wr | input | 1 | Dead-time write strobe |
| dt_val | input | DTW | Dead-time value in clock cycles |
| dt_lock | input | 1 | Write-once lock of the dead-time value |
| moe_set | input | 1 | Request to set main output enable |
| idle_hi | input | 1 | High-side level in the safe state |
| idle_lo | input | 1 | Low-side level in the safe state |
| hiz_hi | input | 1 | Release the high side in the safe state |
| hiz_lo | input | 1 | Release the low side in the safe state |
| hs_drv | output | 1 | High-side gate drive |
| ls_drv | output | 1 | Low-side gate drive |
| hs_en | output | 1 | High-side driver enable |
| ls_en | output | 1 | Low-side driver enable |

## Verification
The properties assume that `brk_pol` changes only while the break condition it selects is inactive. If it changed during an active break, a break could appear or vanish without any change on `brk_in`. They also assume the reference and configuration inputs are synchronous to `clk`. The stimulus changes every input on the falling edge and flips polarity only together with `brk_in`, so the break stays inactive across the change. The dead-time value changes only while the drives are settled, so no gap measurement spans two different dead times.

// File: rtl/deadtime_brk.sv
module deadtime_brk #(
  parameter int DTW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ref_pwm,
  input  logic           brk_in,
  input  logic           brk_pol,
  input  logic           dt_wr,
  input  logic [DTW-1:0] dt_val,
  input  logic           dt_lock,
  input  logic           moe_set,
  input  logic           idle_hi,
  input  logic           idle_lo,
  input  logic           hiz_hi,
  input  logic           hiz_lo,
  output logic           hs_drv,
  output logic           ls_drv,
  output logic           hs_en,
  output logic           ls_en
);
  localparam logic [DTW-1:0] ONE = DTW'(1);

  logic [DTW-1:0] dt_q, cnt_q;
  logic lock_q, moe_q, hs_q, ls_q, hs_en_q, ls_en_q;

  wire brk_act = (brk_in == brk_pol);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dt_q   <= '0;
      lock_q <= 1'b0;
    end else begin
      if (dt_wr && !lock_q) dt_q <= dt_val;
      if (dt_lock) lock_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       moe_q <= 1'b0;
    else if (brk_act) moe_q <= 1'b0;
    else if (moe_set) moe_q <= 1'b1;
  end

  // safe-state targets: low side has priority, a released side stays off
  wire safe_ls = idle_lo & ~hiz_lo;
  wire safe_hs = idle_hi & ~hiz_hi & ~safe_ls;
  wire tgt_hs  = moe_q ? ref_pwm  : safe_hs;
  wire tgt_ls  = moe_q ? ~ref_pwm : safe_ls;

  wire turnoff = (hs_q & ~tgt_hs) | (ls_q & ~tgt_ls);
  wire gap_ok  = (dt_q == '0) | (~turnoff & (cnt_q <= ONE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q    <= 1'b0;
      ls_q    <= 1'b0;
      cnt_q   <= '0;
      hs_en_q <= 1'b0;
      ls_en_q <= 1'b0;
    end else begin
      hs_q    <= tgt_hs & (hs_q | gap_ok);
      ls_q    <= tgt_ls & (ls_q | gap_ok);
      hs_en_q <= moe_q | ~hiz_hi;
      ls_en_q <= moe_q | ~hiz_lo;
      if (turnoff)            cnt_q <= dt_q;
      else if (cnt_q != '0)   cnt_q <= cnt_q - ONE;
    end
  end

  assign hs_drv = hs_q;
  assign ls_drv = ls_q;
  assign hs_en  = hs_en_q;
  assign ls_en  = ls_en_q;
endmodule

// File: rtl/deadtime_brk_chk.sv
module deadtime_brk_chk #(
  parameter int DTW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           brk_in,
  input logic           brk_pol,
  input logic           moe_set,
  input logic           moe_q,
  input logic           lock_q,
  input logic [DTW-1:0] dt_q,
  input logic           hs_drv,
  input logic           ls_drv,
  input logic           hs_en,
  input logic           ls_en
);
  // R2
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_drv && ls_drv));

  // R7
  brk_clears_moe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_in == brk_pol) |=> !moe_q);

  // R8
  moe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(moe_q) |-> ($past(moe_set) && ($past(brk_in) != $past(brk_pol))));

  // R5
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> (lock_q && $stable(dt_q)));

  // R1
  hs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hs_drv) && $past(dt_q) != '0) |-> !$past(ls_drv));

  // R10
  ls_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ls_drv) && $past(dt_q) != '0) |-> !$past(hs_drv));

  // R9
  hiz_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_en |-> !hs_drv) and (!ls_en |-> !ls_drv));
endmodule

bind deadtime_brk deadtime_brk_chk #(.DTW(DTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .brk_in(brk_in), .brk_pol(brk_pol),
  .moe_set(moe_set), .moe_q(moe_q), .lock_q(lock_q), .dt_q(dt_q),
  .hs_drv(hs_drv), .ls_drv(ls_drv), .hs_en(hs_en), .ls_en(ls_en)
);

// File: tb/sim_deadtime_brk.sv
module sim_deadtime_brk;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_pwm = 1'b0, brk_in = 1'b0, brk_pol = 1'b1;
  logic dt_wr = 1'b0, dt_lock = 1'b0, moe_set = 1'b0;
  logic [7:0] dt_val = '0;
  logic idle_hi = 1'b0, idle_lo = 1'b0, hiz_hi = 1'b0, hiz_lo = 1'b0;
  logic hs_drv, ls_drv, hs_en, ls_en;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  typedef struct {
    int    at;
    logic  h, l, eh, el;
    string tag;
  } exp_t;
  exp_t q[$];
  exp_t e;

  deadtime_brk #(.DTW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_pwm(ref_pwm), .brk_in(brk_in), .brk_pol(brk_pol),
    .dt_wr(dt_wr), .dt_val(dt_val), .dt_lock(dt_lock), .moe_set(moe_set),
    .idle_hi(idle_hi), .idle_lo(idle_lo), .hiz_hi(hiz_hi), .hiz_lo(hiz_lo),
    .hs_drv(hs_drv), .ls_drv(ls_drv), .hs_en(hs_en), .ls_en(ls_en)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: each posedge result is looked at on the following falling edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      e = q.pop_front();
      checks++;
      if (e.at != cyc || hs_drv !== e.h || ls_drv !== e.l || hs_en !== e.eh || ls_en !== e.el) begin
        errors++;
        $display("FAIL %s cyc %0d: got hs=%b ls=%b hse=%b lse=%b expected hs=%b ls=%b hse=%b lse=%b",
                 e.tag, e.at, hs_drv, ls_drv, hs_en, ls_en, e.h, e.l, e.eh, e.el);
      end
    end
  end

  task automatic nxt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic want(input int at, input logic h, input logic l, input logic eh,
                      input logic el, input string tag);
    exp_t x;
    x.at = at; x.h = h; x.l = l; x.eh = eh; x.el = el; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic step_ref(input logic v, input int d, input string tag);
    int c;
    c = cyc;
    ref_pwm = v;
    for (int k = 1; k <= d; k++) want(c + k, 1'b0, 1'b0, 1'b1, 1'b1, tag);
    want(c + d + 1, v, ~v, 1'b1, 1'b1, tag);
    nxt(d + 3);
  endtask

  task automatic write_dt(input logic [7:0] v);
    dt_wr = 1'b1; dt_val = v;
    nxt(1);
    dt_wr = 1'b0;
    nxt(1);
  endtask

  initial begin
    #(8ns * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int c;
    nxt(3);
    checks++;
    if (hs_drv !== 1'b0 || ls_drv !== 1'b0 || hs_en !== 1'b0 || ls_en !== 1'b0) begin
      errors++;
      $display("FAIL R6 reset: got %b%b%b%b expected 0000", hs_drv, ls_drv, hs_en, ls_en);
    end
    rst_n = 1'b1;
    c = cyc;
    want(c + 1, 1'b0, 1'b0, 1'b1, 1'b1, "R6 idle after reset");
    nxt(2);

    write_dt(8'd4);
    ref_pwm = 1'b1;
    nxt(2);
    c = cyc;
    want(c + 2, 1'b0, 1'b0, 1'b1, 1'b1, "R6 ref ignored while MOE clear");
    nxt(3);
    c = cyc;
    moe_set = 1'b1;
    want(c + 1, 1'b0, 1'b0, 1'b1, 1'b1, "R8 MOE not yet driving");
    want(c + 2, 1'b1, 1'b0, 1'b1, 1'b1, "R8 MOE set");
    nxt(1);
    moe_set = 1'b0;
    nxt(3);

    // R1 and R2: each expectation also requires the pair to be non-overlapping
    step_ref(1'b0, 4, "R1/R2 falling ref");
    step_ref(1'b1, 4, "R1/R2 rising ref");

    // R4 short low pulse of two cycles against D=4
    c = cyc;
    ref_pwm = 1'b0;
    for (int k = 1; k <= 4; k++) want(c + k, 1'b0, 1'b0, 1'b1, 1'b1, "R4 short pulse");
    want(c + 5, 1'b1, 1'b0, 1'b1, 1'b1, "R4 short pulse end");
    nxt(2);
    ref_pwm = 1'b1;
    nxt(6);

    write_dt(8'd0);
    step_ref(1'b0, 0, "R3 zero dead time");
    step_ref(1'b1, 0, "R3 zero dead time");

    // R5 lock then attempted overwrite with zero
    write_dt(8'd3);
    dt_lock = 1'b1;
    nxt(1);
    dt_lock = 1'b0;
    write_dt(8'd0);
    nxt(1);
    step_ref(1'b0, 3, "R5 locked dead time");
    step_ref(1'b1, 3, "R5 locked dead time");

    // R10 break entry with low side as safe state
    idle_lo = 1'b1;
    nxt(1);
    c = cyc;
    brk_in = 1'b1;
    want(c + 1, 1'b1, 1'b0, 1'b1, 1'b1, "R7 break one edge");
    for (int k = 2; k <= 4; k++) want(c + k, 1'b0, 1'b0, 1'b1, 1'b1, "R10 gap on entry");
    want(c + 5, 1'b0, 1'b1, 1'b1, 1'b1, "R10 safe low side on");
    nxt(7);

    c = cyc;
    moe_set = 1'b1;
    nxt(1);
    moe_set = 1'b0;
    want(c + 3, 1'b0, 1'b1, 1'b1, 1'b1, "R8 set ignored in break");
    nxt(4);

    c = cyc;
    hiz_hi = 1'b1; hiz_lo = 1'b1;
    want(c + 1, 1'b0, 1'b0, 1'b0, 1'b0, "R9 released");
    nxt(3);
    c = cyc;
    hiz_hi = 1'b0; hiz_lo = 1'b0; idle_hi = 1'b1;
    want(c + 8, 1'b0, 1'b1, 1'b1, 1'b1, "R9 both idle high");
    nxt(9);

    brk_in = 1'b0; idle_hi = 1'b0;
    nxt(1);
    c = cyc;
    moe_set = 1'b1;
    want(c + 1, 1'b0, 1'b1, 1'b1, 1'b1, "R8 restart");
    for (int k = 2; k <= 4; k++) want(c + k, 1'b0, 1'b0, 1'b1, 1'b1, "R10 gap on restart");
    want(c + 5, 1'b1, 1'b0, 1'b1, 1'b1, "R8 restart drives");
    nxt(1);
    moe_set = 1'b0;
    nxt(6);

    brk_pol = 1'b0; brk_in = 1'b1;
    nxt(2);
    c = cyc;
    brk_in = 1'b0;
    want(c + 1, 1'b1, 1'b0, 1'b1, 1'b1, "R7 low-active break");
    for (int k = 2; k <= 4; k++) want(c + k, 1'b0, 1'b0, 1'b1, 1'b1, "R7 low-active gap");
    want(c + 5, 1'b0, 1'b1, 1'b1, 1'b1, "R7 low-active safe");
    nxt(7);

    c = cyc;
    idle_lo = 1'b0; idle_hi = 1'b1;
    want(c + 1, 1'b0, 1'b0, 1'b1, 1'b1, "R9 idle swap gap");
    want(c + 4, 1'b1, 1'b0, 1'b1, 1'b1, "R9 idle high side");
    nxt(6);

    nxt(3);
    if (q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL R6 pending: got %0d left expected 0", q.size());
    end
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule